// File: doc/BRIEF.md
# JTAG Test Access Port with Serial-Flash Tunnel

This block is a JTAG test access port that runs entirely on the system clock. It samples the external TCK, TMS, TDI and TRST lines, detects TCK edges in the system clock domain, and runs the sixteen-state TAP controller. It carries a 5-bit instruction register with three behaviours: an identification register, a single-bit bypass, and a tunnel instruction. With the tunnel instruction loaded, a data-register scan becomes a transparent SPI transfer to a serial flash.

During a tunnel scan, TDI drives flash MOSI and gated TCK drives flash SCK. Flash MISO returns on TDO, and flash chip select stays low from Capture-DR until Exit1-DR. Chip select drops before the clock is enabled, so no SCK edge arrives together with the chip-select edge. MISO reaches TDO through a single system-clock register, so read data is not delayed by a TCK period.

The flash pins are shared with an existing execute-in-place SPI master. The tunnel takes the pins whenever its chip select is low. A host can therefore program the flash with an ordinary JTAG adapter, with no separate flash programmer.

Top module: `jtag_spi_tap`

## Requirements
- R1: Five TCK rising edges with TMS high put the controller in Test-Logic-Reset and select the identification instruction (code 5'b00001). A following DR scan then returns the identification value.
- R2: While TRST (active low) is low, the controller is held in Test-Logic-Reset with the identification instruction selected.
- R3: With the identification instruction selected, a DR scan shifts out 32'h0CAFE001, least significant bit first.
- R4: A Shift-IR pass shifts out the capture value 5'b00001, least significant bit first. The 5 bits shifted in, least significant bit first, become the instruction at Update-IR.
- R5: Code 5'b11111 and every unassigned code (any code other than 5'b00001 and 5'b10010) select a one-bit bypass that captures 0. An N-bit scan returns the input delayed by one bit.
- R6: With code 5'b10010 loaded, flash chip select goes low in Capture-DR. During the shift, flash MOSI equals TDI at every SCK rising edge.
- R7: Flash SCK stays low when chip select falls. SCK is enabled during Shift-DR, so an N-bit tunnel scan produces exactly N SCK rising edges, all with chip select low.
- R8: On entry to Exit1-DR the tunnel releases chip select and stops SCK.
- R9: While the tunnel is active, TDO follows flash MISO after one system clock, at any point of the TCK period.
- R10: Outside the tunnel, TDO changes only in the system clock following a detected falling TCK edge.
- R11: Flash chip select is the AND of the tunnel and execute-in-place chip selects. SCK and MOSI come from the tunnel while the tunnel chip select is low, and from the execute-in-place master otherwise.
- R12: With any instruction other than 5'b10010, a DR scan never asserts the tunnel chip select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tck_i | input | 1 | JTAG test clock, sampled asynchronously |
| tms_i | input | 1 | JTAG mode select |
| tdi_i | input | 1 | JTAG serial data in |
| trst_n_i | input | 1 | JTAG reset, active low |
| tdo_o | output | 1 | JTAG serial data out |
| xip_cs_n_i | input | 1 | Execute-in-place master chip select, active low |
| xip_sck_i | input | 1 | Execute-in-place master serial clock |
| xip_mosi_i | input | 1 | Execute-in-place master data out |
| flash_miso_i | input | 1 | Serial data from the flash |
| flash_cs_n_o | output | 1 | Shared flash chip select, active low |
| flash_sck_o | output | 1 | Shared flash serial clock |
| flash_mosi_o | output | 1 | Shared flash data in |

## Verification
A controller state that has drifted shows up within one TCK period. TDO then carries the wrong capture pattern, or no identification value, on the next IR or DR scan. A stuck or misplaced tunnel flag is visible on the flash pins: chip select changes at the wrong TAP state, or the SCK edge count differs from the number of shifted bits. It also shows as a chip-select fall with SCK already high. A wrong TDO source is caught within two system clocks by toggling MISO in the middle of a TCK phase, and by watching for TDO changes while TCK is high outside the tunnel.

// File: rtl/jtag_spi_tap.sv
module jtag_spi_tap #(
  parameter int              IR_W      = 5,
  parameter int              ID_W      = 32,
  parameter logic [IR_W-1:0] IR_IDCODE = 5'b00001,
  parameter logic [IR_W-1:0] IR_TUNNEL = 5'b10010,
  parameter logic [ID_W-1:0] ID_VALUE  = 32'h0CAFE001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tck_i,
  input  logic tms_i,
  input  logic tdi_i,
  input  logic trst_n_i,
  output logic tdo_o,
  input  logic xip_cs_n_i,
  input  logic xip_sck_i,
  input  logic xip_mosi_i,
  input  logic flash_miso_i,
  output logic flash_cs_n_o,
  output logic flash_sck_o,
  output logic flash_mosi_o
);

  typedef enum logic [3:0] {
    TLR, RTI,
    SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UPD_IR
  } tap_t;

  logic [2:0] tck_q;
  logic [1:0] tms_q, tdi_q, trst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tck_q  <= '0;
      tms_q  <= '0;
      tdi_q  <= '0;
      trst_q <= '0;
    end else begin
      tck_q  <= {tck_q[1:0], tck_i};
      tms_q  <= {tms_q[0], tms_i};
      tdi_q  <= {tdi_q[0], tdi_i};
      trst_q <= {trst_q[0], trst_n_i};
    end
  end

  wire tck_s    = tck_q[1];
  wire tms_s    = tms_q[1];
  wire tdi_s    = tdi_q[1];
  wire trst_s   = trst_q[1];
  wire tck_rise = tck_q[1] & ~tck_q[2];
  wire tck_fall = ~tck_q[1] & tck_q[2];

  tap_t state, nxt;

  always_comb begin
    case (state)
      TLR:     nxt = tms_s ? TLR    : RTI;
      RTI:     nxt = tms_s ? SEL_DR : RTI;
      SEL_DR:  nxt = tms_s ? SEL_IR : CAP_DR;
      CAP_DR:  nxt = tms_s ? EX1_DR : SH_DR;
      SH_DR:   nxt = tms_s ? EX1_DR : SH_DR;
      EX1_DR:  nxt = tms_s ? UPD_DR : PA_DR;
      PA_DR:   nxt = tms_s ? EX2_DR : PA_DR;
      EX2_DR:  nxt = tms_s ? UPD_DR : SH_DR;
      UPD_DR:  nxt = tms_s ? SEL_DR : RTI;
      SEL_IR:  nxt = tms_s ? TLR    : CAP_IR;
      CAP_IR:  nxt = tms_s ? EX1_IR : SH_IR;
      SH_IR:   nxt = tms_s ? EX1_IR : SH_IR;
      EX1_IR:  nxt = tms_s ? UPD_IR : PA_IR;
      PA_IR:   nxt = tms_s ? EX2_IR : PA_IR;
      EX2_IR:  nxt = tms_s ? UPD_IR : SH_IR;
      UPD_IR:  nxt = tms_s ? SEL_DR : RTI;
      default: nxt = TLR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         state <= TLR;
    else if (!trst_s)   state <= TLR;
    else if (tck_rise)  state <= nxt;
  end

  logic [IR_W-1:0] ir, ir_sh;
  logic [ID_W-1:0] id_sh;
  logic            byp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir    <= IR_IDCODE;
      ir_sh <= '0;
      id_sh <= '0;
      byp   <= 1'b0;
    end else if (state == TLR) begin
      ir <= IR_IDCODE;
    end else if (tck_rise) begin
      case (state)
        CAP_IR: ir_sh <= IR_W'(1);
        SH_IR:  ir_sh <= {tdi_s, ir_sh[IR_W-1:1]};
        UPD_IR: ir    <= ir_sh;
        CAP_DR: begin id_sh <= ID_VALUE; byp <= 1'b0; end
        SH_DR:  begin id_sh <= {tdi_s, id_sh[ID_W-1:1]}; byp <= tdi_s; end
        default: ;
      endcase
    end
  end

  logic spi_act, sck_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spi_act <= 1'b0;
      sck_en  <= 1'b0;
    end else if (ir != IR_TUNNEL || state == EX1_DR || state == TLR) begin
      spi_act <= 1'b0;
      sck_en  <= 1'b0;
    end else begin
      if (state == CAP_DR) spi_act <= 1'b1;
      if (state == SH_DR && spi_act && !tck_s) sck_en <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tdo_o <= 1'b0;
    else if (spi_act)
      tdo_o <= flash_miso_i;
    else if (tck_fall) begin
      if (state == SH_IR)      tdo_o <= ir_sh[0];
      else if (state == SH_DR) tdo_o <= (ir == IR_IDCODE) ? id_sh[0] : byp;
    end
  end

  wire tun_cs_n = ~spi_act;
  wire tun_sck  = tck_s & sck_en;

  assign flash_cs_n_o = tun_cs_n & xip_cs_n_i;
  assign flash_sck_o  = tun_cs_n ? xip_sck_i  : tun_sck;
  assign flash_mosi_o = tun_cs_n ? xip_mosi_i : tdi_s;

  assert_trst_holds_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !trst_s |=> state == TLR);

  assert_cs_falls_with_sck_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_act) |-> !tun_sck);

  assert_sck_only_in_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tun_sck |-> (state == SH_DR || state == EX1_DR));

  assert_exit1_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
    state == EX1_DR |=> (!spi_act && !sck_en));

  assert_tdo_tracks_miso_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(spi_act) |-> tdo_o == $past(flash_miso_i));

  assert_tdo_only_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(spi_act) && !$past(tck_fall)) |-> $stable(tdo_o));

  assert_no_tunnel_other_ir_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ir != IR_TUNNEL |=> !spi_act);

endmodule

// File: tb/sim_jtag_spi_tap.sv
`timescale 1ns/1ps
module sim_jtag_spi_tap;
  localparam int HALF = 8;

  logic clk = 0, rst_n = 0;
  logic tck_i = 0, tms_i = 1, tdi_i = 0, trst_n_i = 1;
  logic xip_cs_n_i = 1, xip_sck_i = 0, xip_mosi_i = 0, flash_miso_i = 0;
  logic tdo_o, flash_cs_n_o, flash_sck_o, flash_mosi_o;

  always #2.5 clk = ~clk;

  jtag_spi_tap u0 (
    .clk(clk), .rst_n(rst_n), .tck_i(tck_i), .tms_i(tms_i), .tdi_i(tdi_i),
    .trst_n_i(trst_n_i), .tdo_o(tdo_o), .xip_cs_n_i(xip_cs_n_i),
    .xip_sck_i(xip_sck_i), .xip_mosi_i(xip_mosi_i), .flash_miso_i(flash_miso_i),
    .flash_cs_n_o(flash_cs_n_o), .flash_sck_o(flash_sck_o), .flash_mosi_o(flash_mosi_o)
  );

  int tests = 0, fails = 0;
  int sck_rises = 0, sck_nocs = 0, tdo_bad = 0, cs_low_cnt = 0;
  logic [31:0] mosi_seen = '0;
  logic mon_tdo = 0, mon_cs = 0, tdo_prev = 0;

  always @(posedge flash_sck_o) begin
    if (sck_rises < 32) mosi_seen[sck_rises] = flash_mosi_o;
    if (flash_cs_n_o) sck_nocs++;
    sck_rises++;
  end

  always @(negedge clk) begin
    if (mon_tdo && tdo_o !== tdo_prev && tck_i) tdo_bad++;
    tdo_prev = tdo_o;
    if (mon_cs && !flash_cs_n_o) cs_low_cnt++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tck_cycle(input logic tms, input logic tdi, output logic tdo);
    tms_i = tms; tdi_i = tdi; tck_i = 0;
    repeat (HALF) @(posedge clk);
    #1 tdo = tdo_o;
    tck_i = 1;
    repeat (HALF) @(posedge clk);
    #1;
  endtask

  task automatic tap_reset();
    logic d;
    for (int i = 0; i < 5; i++) tck_cycle(1'b1, 1'b0, d);
    tck_cycle(1'b0, 1'b0, d);
  endtask

  task automatic shift_ir(input logic [4:0] code, output logic [4:0] cap);
    logic d;
    tck_cycle(1, 0, d); tck_cycle(1, 0, d); tck_cycle(0, 0, d); tck_cycle(0, 0, d);
    for (int i = 0; i < 5; i++) tck_cycle(i == 4, code[i], cap[i]);
    tck_cycle(1, 0, d); tck_cycle(0, 0, d);
  endtask

  task automatic shift_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    logic d;
    dout = '0;
    tck_cycle(1, 0, d); tck_cycle(0, 0, d); tck_cycle(0, 0, d);
    for (int i = 0; i < n; i++) tck_cycle(i == n - 1, din[i], dout[i]);
    tck_cycle(1, 0, d); tck_cycle(0, 0, d);
  endtask

  task automatic t_reset_state();
    check(flash_cs_n_o === 1'b1, "R11 reset cs", {31'b0, flash_cs_n_o}, 32'd1);
    check(tdo_o === 1'b0, "R10 reset tdo", {31'b0, tdo_o}, 32'd0);
    check(flash_sck_o === 1'b0, "R11 reset sck", {31'b0, flash_sck_o}, 32'd0);
  endtask

  task automatic t_idcode();
    logic [31:0] q;
    tap_reset();
    mon_tdo = 1; mon_cs = 1; cs_low_cnt = 0; tdo_bad = 0;
    shift_dr(32, 32'h0, q);
    mon_tdo = 0; mon_cs = 0;
    check(q === 32'h0CAFE001, "R3 idcode", q, 32'h0CAFE001);
    check(tdo_bad == 0, "R10 tdo moved with tck high", tdo_bad, 0);
    check(cs_low_cnt == 0, "R12 cs asserted outside tunnel", cs_low_cnt, 0);
  endtask

  task automatic t_ir_capture();
    logic [4:0] cap;
    shift_ir(5'b00001, cap);
    check(cap === 5'b00001, "R4 ir capture", {27'b0, cap}, 32'd1);
  endtask

  task automatic t_bypass();
    logic [4:0] cap;
    logic [31:0] q;
    shift_ir(5'b00111, cap);
    mon_cs = 1; cs_low_cnt = 0;
    shift_dr(8, 32'hA5, q);
    mon_cs = 0;
    check(q[7:0] === 8'h4A, "R5 unassigned bypass", {24'b0, q[7:0]}, 32'h4A);
    check(cs_low_cnt == 0, "R12 no cs in bypass", cs_low_cnt, 0);
    shift_ir(5'b11111, cap);
    shift_dr(8, 32'h3C, q);
    check(q[7:0] === 8'h78, "R5 bypass", {24'b0, q[7:0]}, 32'h78);
  endtask

  task automatic t_tunnel();
    logic [4:0] cap;
    logic [7:0] pat_in, pat_miso, rd;
    logic d;
    pat_in = 8'hC3; pat_miso = 8'h5A;
    shift_ir(5'b10010, cap);
    xip_cs_n_i = 1; xip_sck_i = 1; xip_mosi_i = 1;
    tck_cycle(1, 0, d);
    check(flash_cs_n_o === 1'b1, "R6 cs high before capture", {31'b0, flash_cs_n_o}, 1);
    tck_cycle(0, 0, d);
    check(flash_cs_n_o === 1'b0, "R6 cs low in capture", {31'b0, flash_cs_n_o}, 0);
    check(flash_sck_o === 1'b0, "R7 sck low at cs fall", {31'b0, flash_sck_o}, 0);
    sck_rises = 0; sck_nocs = 0; mosi_seen = '0;
    tck_cycle(0, 0, d);
    tck_i = 0;
    repeat (4) @(posedge clk);
    #1 flash_miso_i = 1;
    repeat (2) @(posedge clk);
    #1 check(tdo_o === 1'b1, "R9 miso to tdo rise", {31'b0, tdo_o}, 1);
    flash_miso_i = 0;
    repeat (2) @(posedge clk);
    #1 check(tdo_o === 1'b0, "R9 miso to tdo fall", {31'b0, tdo_o}, 0);
    check(flash_sck_o === 1'b0, "R11 tunnel owns sck", {31'b0, flash_sck_o}, 0);
    for (int i = 0; i < 8; i++) begin
      flash_miso_i = pat_miso[i];
      tck_cycle(i == 7, pat_in[i], rd[i]);
    end
    repeat (2) @(posedge clk);
    #1;
    check(flash_cs_n_o === 1'b1, "R8 cs released at exit1", {31'b0, flash_cs_n_o}, 1);
    check(sck_rises == 8, "R7 sck edge count", sck_rises, 8);
    check(sck_nocs == 0, "R7 sck without cs", sck_nocs, 0);
    check(mosi_seen[7:0] === pat_in, "R6 mosi bits", {24'b0, mosi_seen[7:0]}, {24'b0, pat_in});
    check(rd === pat_miso, "R9 miso read data", {24'b0, rd}, {24'b0, pat_miso});
    tck_cycle(1, 0, d); tck_cycle(0, 0, d);
    check(flash_sck_o === 1'b1 && flash_mosi_o === 1'b1, "R11 xip sck/mosi restored",
          {30'b0, flash_sck_o, flash_mosi_o}, 32'd3);
    xip_sck_i = 0; xip_mosi_i = 0;
  endtask

  task automatic t_mux();
    xip_cs_n_i = 0; xip_sck_i = 1; xip_mosi_i = 0;
    @(posedge clk); #1;
    check(flash_cs_n_o === 1'b0 && flash_sck_o === 1'b1 && flash_mosi_o === 1'b0,
          "R11 xip passthrough", {29'b0, flash_cs_n_o, flash_sck_o, flash_mosi_o}, 32'd2);
    xip_cs_n_i = 1; xip_sck_i = 0;
  endtask

  task automatic t_trst_and_tms_reset();
    logic [4:0] cap;
    logic [31:0] q;
    shift_ir(5'b10010, cap);
    trst_n_i = 0;
    repeat (6) @(posedge clk);
    #1 trst_n_i = 1;
    repeat (4) @(posedge clk);
    #1;
    begin logic d; tck_cycle(0, 0, d); end
    mon_cs = 1; cs_low_cnt = 0;
    shift_dr(32, 32'h0, q);
    mon_cs = 0;
    check(q === 32'h0CAFE001, "R2 trst selects idcode", q, 32'h0CAFE001);
    check(cs_low_cnt == 0, "R2 trst leaves tunnel off", cs_low_cnt, 0);
    shift_ir(5'b00111, cap);
    tap_reset();
    shift_dr(32, 32'h0, q);
    check(q === 32'h0CAFE001, "R1 tms reset selects idcode", q, 32'h0CAFE001);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    t_reset_state();
    t_idcode();
    t_ir_capture();
    t_bypass();
    t_mux();
    t_tunnel();
    t_trst_and_tms_reset();
    finish_run();
  end
endmodule